// File: doc/BRIEF.md
# Per-Channel Zero-Run Flag Generator

This block watches the left and right sample streams headed for a stereo DAC. Each stream has its own valid strobe. For each channel the block detects a long run of all-zero samples. A channel is declared silent once a parameterised number of consecutive zero samples has arrived on it. The default run length is 1024 samples. The run counter saturates, so the detection holds for as long as the zeros keep coming. A single nonzero sample restarts the run.

Each channel's detection counts only while that channel is routed into the output summing stage. A 2-bit select steers the two gated detections onto two flag pins, where a 1 means silence:
- off
- per channel
- both silent
- either silent

An auto-mute enable turns each channel's own gated detection into a mute request for that channel's output gain stage. The mute circuitry and the sample datapath sit outside this block.

Top module: `dac_zero_watch`

## Requirements
- R1: A channel's detection asserts on the clock edge that accepts its RUN_LEN-th consecutive zero-valued valid sample (RUN_LEN defaults to 1024). After RUN_LEN-1 such samples it is still low.
- R2: A valid sample with any nonzero bit clears that channel's run count and detection at that edge. A fresh run of RUN_LEN zero samples is then needed.
- R3: A sample is counted only on a cycle where that channel's valid strobe is 1. Data on cycles with the strobe at 0 does not change the run, whether it is zero or nonzero.
- R4: Once asserted, a detection stays high while further zero samples arrive, because the count saturates at RUN_LEN.
- R5: With flag_sel = 2'b00, flag_l and flag_r are both 0.
- R6: With flag_sel = 2'b01, flag_l follows the left gated detection and flag_r follows the right gated detection.
- R7: With flag_sel = 2'b10, both flags are 1 only when both gated detections are 1.
- R8: With flag_sel = 2'b11, both flags are 1 when at least one gated detection is 1.
- R9: A channel whose route enable is 0 contributes 0 to the flags and to its mute request. Its run counting continues, so re-enabling the route shows the current detection at once.
- R10: With auto_mute_en = 1, mute_req_l and mute_req_r each equal their own channel's gated detection. With auto_mute_en = 0, both are 0.
- R11: After reset, the run counts are zero and all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_data | input | DATA_W | Left sample |
| l_vld | input | 1 | Left sample valid strobe |
| r_data | input | DATA_W | Right sample |
| r_vld | input | 1 | Right sample valid strobe |
| l_route_en | input | 1 | Left channel feeds the summing stage |
| r_route_en | input | 1 | Right channel feeds the summing stage |
| flag_sel | input | 2 | Flag steering: 00 off, 01 per channel, 10 both, 11 either |
| auto_mute_en | input | 1 | Enable mute requests from detections |
| flag_l | output | 1 | Left flag pin, 1 = zero detected |
| flag_r | output | 1 | Right flag pin, 1 = zero detected |
| mute_req_l | output | 1 | Left mute request |
| mute_req_r | output | 1 | Right mute request |

## Verification
The bench builds the block with RUN_LEN = 12 and DATA_W = 16. The shorter run brings the threshold edge, saturation and restart within a few dozen cycles per scenario. It also makes it cheap to hold one channel silent and the other active, which every steering code and routing mask needs. A 12-sample run exercises the same counter compare and saturation logic as the 1024 default, only with a narrower count.

// File: rtl/zw_pkg.sv
package zw_pkg;
   typedef enum logic [1:0] {
      ZW_OFF = 2'b00,
      ZW_SEP = 2'b01,
      ZW_ALL = 2'b10,
      ZW_ANY = 2'b11
   } zw_sel_e;

   localparam int ZW_NCH = 2;
   localparam int ZW_LEFT = 0;
   localparam int ZW_RIGHT = 1;
endpackage

// File: rtl/zw_run_det.sv
module zw_run_det #(
   parameter int DATA_W  = 24,
   parameter int RUN_LEN = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] smp,
   input  logic              vld,
   output logic              det
);
   localparam int CNT_W = $clog2(RUN_LEN + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

   if (RUN_LEN < 2) begin : g_bad_len
      $error("zw_run_det: RUN_LEN must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("zw_run_det: DATA_W must be positive");
   end

   logic [CNT_W-1:0] cnt;
   logic             is_zero;

   assign is_zero = (smp == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (vld) begin
         if (!is_zero) begin
            cnt <= '0;
         end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign det = (cnt == LIMIT);

   a_r4_sat_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIMIT);
   a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !is_zero) |=> !det);
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |=> $stable(cnt));
   a_r4_stay: assert property (@(posedge clk) disable iff (!rst_n)
      (det && vld && is_zero) |=> det);
endmodule

// File: rtl/zw_flag_steer.sv
module zw_flag_steer
   import zw_pkg::*;
(
   input  logic [ZW_NCH-1:0] gdet,
   input  logic [1:0]        sel,
   output logic              flag_l,
   output logic              flag_r
);
   zw_sel_e mode;
   logic    both_z;
   logic    any_z;

   assign mode   = zw_sel_e'(sel);
   assign both_z = &gdet;
   assign any_z  = |gdet;

   always_comb begin
      flag_l = 1'b0;
      flag_r = 1'b0;
      unique case (mode)
         ZW_OFF: begin
            flag_l = 1'b0;
            flag_r = 1'b0;
         end
         ZW_SEP: begin
            flag_l = gdet[ZW_LEFT];
            flag_r = gdet[ZW_RIGHT];
         end
         ZW_ALL: begin
            flag_l = both_z;
            flag_r = both_z;
         end
         ZW_ANY: begin
            flag_l = any_z;
            flag_r = any_z;
         end
         default: begin
            flag_l = 1'b0;
            flag_r = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/zw_mute_req.sv
module zw_mute_req
   import zw_pkg::*;
(
   input  logic              auto_en,
   input  logic [ZW_NCH-1:0] gdet,
   output logic [ZW_NCH-1:0] req
);
   for (genvar c = 0; c < ZW_NCH; c++) begin : g_req
      assign req[c] = auto_en & gdet[c];
   end
endmodule

// File: rtl/dac_zero_watch.sv
module dac_zero_watch
   import zw_pkg::*;
#(
   parameter int DATA_W  = 24,
   parameter int RUN_LEN = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] l_data,
   input  logic              l_vld,
   input  logic [DATA_W-1:0] r_data,
   input  logic              r_vld,
   input  logic              l_route_en,
   input  logic              r_route_en,
   input  logic [1:0]        flag_sel,
   input  logic              auto_mute_en,
   output logic              flag_l,
   output logic              flag_r,
   output logic              mute_req_l,
   output logic              mute_req_r
);
   logic [DATA_W-1:0] ch_smp [ZW_NCH];
   logic [ZW_NCH-1:0] ch_vld;
   logic [ZW_NCH-1:0] ch_route;
   logic [ZW_NCH-1:0] det_raw;
   logic [ZW_NCH-1:0] det_g;
   logic [ZW_NCH-1:0] req;

   assign ch_smp[ZW_LEFT]    = l_data;
   assign ch_smp[ZW_RIGHT]   = r_data;
   assign ch_vld[ZW_LEFT]    = l_vld;
   assign ch_vld[ZW_RIGHT]   = r_vld;
   assign ch_route[ZW_LEFT]  = l_route_en;
   assign ch_route[ZW_RIGHT] = r_route_en;

   for (genvar c = 0; c < ZW_NCH; c++) begin : g_ch
      zw_run_det #(
         .DATA_W  (DATA_W),
         .RUN_LEN (RUN_LEN)
      ) u_run (
         .clk   (clk),
         .rst_n (rst_n),
         .smp   (ch_smp[c]),
         .vld   (ch_vld[c]),
         .det   (det_raw[c])
      );
      assign det_g[c] = det_raw[c] & ch_route[c];
   end

   zw_flag_steer u_steer (
      .gdet   (det_g),
      .sel    (flag_sel),
      .flag_l (flag_l),
      .flag_r (flag_r)
   );

   zw_mute_req u_mute (
      .auto_en (auto_mute_en),
      .gdet    (det_g),
      .req     (req)
   );

   assign mute_req_l = req[ZW_LEFT];
   assign mute_req_r = req[ZW_RIGHT];

   a_r5_off: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_sel == 2'b00) |-> (!flag_l && !flag_r));
   a_r7_both: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_sel == 2'b10 && flag_l) |-> (mute_req_l == auto_mute_en && mute_req_r == auto_mute_en));
   a_r8_equal: assert property (@(posedge clk) disable iff (!rst_n)
      flag_sel[1] |-> (flag_l == flag_r));
   a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !l_route_en |-> !mute_req_l);
   a_r10_off: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_mute_en |-> (!mute_req_l && !mute_req_r));
endmodule

// File: tb/dac_zero_watch_tb.sv
module dac_zero_watch_tb;
   localparam int CLK_PER = 10;
   localparam int DW = 16;
   localparam int RL = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] l_data = '0;
   logic          l_vld = 1'b0;
   logic [DW-1:0] r_data = '0;
   logic          r_vld = 1'b0;
   logic          l_route_en = 1'b1;
   logic          r_route_en = 1'b1;
   logic [1:0]    flag_sel = 2'b01;
   logic          auto_mute_en = 1'b1;
   logic          flag_l, flag_r, mute_req_l, mute_req_r;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PER/2) clk = ~clk;

   dac_zero_watch #(.DATA_W(DW), .RUN_LEN(RL)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .l_data(l_data), .l_vld(l_vld), .r_data(r_data), .r_vld(r_vld),
      .l_route_en(l_route_en), .r_route_en(r_route_en),
      .flag_sel(flag_sel), .auto_mute_en(auto_mute_en),
      .flag_l(flag_l), .flag_r(flag_r),
      .mute_req_l(mute_req_l), .mute_req_r(mute_req_r));

   task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: {flag_l,flag_r,mute_l,mute_r} got %b expected %b", req, got, exp);
      end
   endtask

   function automatic logic [3:0] outs();
      return {flag_l, flag_r, mute_req_l, mute_req_r};
   endfunction

   task automatic push(input int n, input logic [DW-1:0] ld, input logic lv,
                       input logic [DW-1:0] rd, input logic rv);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         l_data = ld; l_vld = lv; r_data = rd; r_vld = rv;
         @(posedge clk);
         #1;
         l_vld = 1'b0; r_vld = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      l_route_en = 1'b1; r_route_en = 1'b1;
      flag_sel = 2'b01; auto_mute_en = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      chk("R11 reset", outs(), 4'b0000);
   endtask

   task automatic t_run();
      do_reset();
      push(RL-1, '0, 1'b1, 16'h0005, 1'b1);
      chk("R1 one short of run", outs(), 4'b0000);
      push(1, '0, 1'b1, 16'h0005, 1'b1);
      chk("R1/R6/R10 run reached left", outs(), 4'b1010);
      push(5, '0, 1'b1, 16'h0005, 1'b1);
      chk("R4 saturate holds", outs(), 4'b1010);
      push(1, 16'h8000, 1'b1, 16'h0005, 1'b1);
      chk("R2 nonzero clears", outs(), 4'b0000);
      push(RL-1, '0, 1'b1, 16'h0005, 1'b1);
      chk("R2 fresh run needed", outs(), 4'b0000);
      push(1, '0, 1'b1, 16'h0005, 1'b1);
      chk("R2 fresh run completes", outs(), 4'b1010);
   endtask

   task automatic t_valid();
      do_reset();
      push(RL-1, '0, 1'b1, '0, 1'b0);
      push(6, '0, 1'b0, '0, 1'b0);
      chk("R3 invalid zeros not counted", outs(), 4'b0000);
      push(4, 16'h1234, 1'b0, 16'h1, 1'b0);
      chk("R3 invalid nonzero ignored", outs(), 4'b0000);
      push(1, '0, 1'b1, '0, 1'b0);
      chk("R3 run kept across invalid", outs(), 4'b1010);
   endtask

   task automatic t_steer();
      do_reset();
      push(RL, '0, 1'b1, 16'h0001, 1'b1);
      flag_sel = 2'b10; #1;
      chk("R7 both, only left", outs(), 4'b0010);
      flag_sel = 2'b11; #1;
      chk("R8 either, only left", outs(), 4'b1110);
      flag_sel = 2'b00; #1;
      chk("R5 off", outs(), 4'b0010);
      push(RL, '0, 1'b1, '0, 1'b1);
      chk("R5 off, both silent", outs(), 4'b0011);
      flag_sel = 2'b10; #1;
      chk("R7 both silent", outs(), 4'b1111);
      flag_sel = 2'b01; #1;
      chk("R6 separate both", outs(), 4'b1111);
      push(1, 16'h0002, 1'b1, '0, 1'b1);
      chk("R6 right only", outs(), 4'b0101);
      flag_sel = 2'b11; #1;
      chk("R8 either, only right", outs(), 4'b1101);
   endtask

   task automatic t_route();
      do_reset();
      push(RL, '0, 1'b1, '0, 1'b1);
      l_route_en = 1'b0; #1;
      chk("R9 left unrouted", outs(), 4'b0101);
      push(3, '0, 1'b1, '0, 1'b1);
      l_route_en = 1'b1; #1;
      chk("R9 reroute shows at once", outs(), 4'b1111);
      flag_sel = 2'b11; r_route_en = 1'b0;
      push(1, 16'h0010, 1'b1, '0, 1'b1);
      chk("R9 either with right masked", outs(), 4'b0000);
   endtask

   task automatic t_mute();
      do_reset();
      auto_mute_en = 1'b0;
      push(RL, '0, 1'b1, '0, 1'b1);
      chk("R10 auto-mute off", outs(), 4'b1100);
      auto_mute_en = 1'b1; #1;
      chk("R10 auto-mute on", outs(), 4'b1111);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      t_reset();
      t_run();
      t_valid();
      t_steer();
      t_route();
      t_mute();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule